// File: doc/BRIEF.md
# Prioritized CPU Interrupt Response Controller

This block sits beside a CPU core and decides, at cycle and instruction boundaries, which outside request the core serves next. An external bus master may ask for the buses with an active-low request. The controller grants it at the end of the current machine cycle, floats the core's bus drivers and drives an active-low acknowledge back. A falling edge on the non-maskable pin is caught and held until it is served. An active-low level on the maskable pin is served only when the interrupt-enable flag is set. Both interrupt kinds are looked at only when the core flags the end of an instruction.

When an interrupt is accepted, the enable flag is cleared and the controller produces a jump target for the core. The target goes out on a valid/ready stream. A non-maskable interrupt always goes to a fixed address. A maskable interrupt first runs an acknowledge cycle, one base cycle plus two automatic waits, and samples the device's byte on the data bus in the last of those cycles. It then forms the target according to the selected mode. In mode 0 the byte is an opcode handed to the core. In mode 1 the target is a fixed address. In mode 2 the table register supplies the high byte and the device byte supplies the low byte. The core writes the enable flag, the mode and the table register through plain write strobes.

Back-pressure on the target stream: while `vec_valid` is high and `vec_ready` is low, the target and its kind stay frozen and no further interrupt is accepted. A transfer happens on a clock edge where both are high. `vec_valid` drops on the next cycle unless a new target is loaded.

Top module: `irq_resp_ctl`

## Requirements
- R1: While reset is low, `busack_n` is 1, `bus_oe` is 0, `irq_ack` is 0, `vec_valid` is 0 and `ie_flag` is 0. Reset also selects mode 0 and clears the table register. `bus_oe` goes to 1 on the first clock after release.
- R2: A low `busreq_n` is granted only on a clock where `mcyc_end` is 1. From the next cycle `busack_n` is 0 and `bus_oe` is 0. When `busreq_n` returns high, both return to the released state on the next cycle.
- R3: A bus grant outranks both interrupts. No interrupt is accepted while the grant is held, or on the boundary where the grant is taken.
- R4: A falling edge on `nmi_n` stays pending, even after the pin returns high, until the next accepted instruction end. It is served whatever the state of `ie_flag`. It yields target 0x0066 with `vec_kind` 0 on the cycle after acceptance, and no acknowledge cycle.
- R5: When a non-maskable interrupt is pending and `int_n` is low at the same instruction end, only the non-maskable one is served. The maskable one is judged again at a later instruction end.
- R6: A maskable interrupt is accepted when `instr_end` is 1, `int_n` is 0 and `ie_flag` is 1. `irq_ack` is then high for three cycles starting the cycle after acceptance. `ack_wait` is high in the first two of them. `vec_valid` rises on the cycle after the last one.
- R7: A low `int_n` has no effect when `ie_flag` is 0, or on a cycle without `instr_end`.
- R8: Accepting either interrupt clears `ie_flag`. The flag is visible cleared on the next cycle.
- R9: The maskable target uses the mode held at acceptance and the data byte sampled in the last acknowledge cycle. Mode 0 gives `vec_kind` 1 and target {0x00, byte}. Mode 1 gives `vec_kind` 2 and target 0x0038, ignoring the byte. Mode 2 gives `vec_kind` 3 and target {table register, byte}. Mode code 3 behaves as mode 1.
- R10: While `vec_valid` is 1 and `vec_ready` is 0, `vec_addr` and `vec_kind` hold their values and no interrupt is accepted. A transfer clears `vec_valid` on the next cycle.
- R11: `ie_wr`, `im_wr` and `ireg_wr` load the enable flag, the mode and the table register on the clock where they are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| busreq_n | input | 1 | External bus request, active low |
| nmi_n | input | 1 | Non-maskable request, falling-edge sensed |
| int_n | input | 1 | Maskable request, active-low level |
| mcyc_end | input | 1 | Core strobe: last cycle of a machine cycle |
| instr_end | input | 1 | Core strobe: last cycle of an instruction |
| ie_wr | input | 1 | Load strobe for the enable flag |
| ie_wdata | input | 1 | Value for the enable flag |
| im_wr | input | 1 | Load strobe for the mode |
| im_wdata | input | 2 | Mode value (0, 1, 2; 3 acts as 1) |
| ireg_wr | input | 1 | Load strobe for the table register |
| ireg_wdata | input | 8 | Table register value |
| data_in | input | 8 | Data bus byte from the interrupting device |
| busack_n | output | 1 | Bus grant acknowledge, active low |
| bus_oe | output | 1 | Enable for the core's bus and strobe drivers |
| ie_flag | output | 1 | Current interrupt-enable flag |
| irq_ack | output | 1 | Maskable acknowledge cycle in progress |
| ack_wait | output | 1 | Acknowledge cycle is in an automatic wait |
| vec_valid | output | 1 | Target stream valid |
| vec_ready | input | 1 | Target stream ready |
| vec_addr | output | 16 | Jump target, or opcode in the low byte for mode 0 |
| vec_kind | output | 2 | 0 non-maskable, 1 opcode, 2 fixed, 3 table |

## Verification
The maskable path is swept over all four mode codes, three table register values and four data bytes. The expected target is computed arithmetically, so a wrong byte lane, a wrong fixed address or a wrong mode decode each stand out. The data byte is changed between the first and the last acknowledge cycle, which separates sampling in the last cycle from sampling at acceptance. Priority is tried with pairs and triples of requests landing on the same boundary, and against a stalled target stream. This tells a dropped non-maskable edge apart from one that is only deferred.

// File: rtl/irq_resp_pkg.sv
package irq_resp_pkg;
  typedef enum logic [1:0] {
    VK_NMI    = 2'd0,
    VK_OPCODE = 2'd1,
    VK_FIXED  = 2'd2,
    VK_TABLE  = 2'd3
  } vec_kind_e;

  typedef enum logic [1:0] {
    MODE_OPCODE = 2'd0,
    MODE_FIXED  = 2'd1,
    MODE_TABLE  = 2'd2,
    MODE_ALIAS  = 2'd3
  } int_mode_e;

  localparam logic [15:0] NMI_TARGET   = 16'h0066;
  localparam logic [15:0] FIXED_TARGET = 16'h0038;
endpackage

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_n,
  input  logic served,
  output logic pending
);
  logic pin_q;
  logic fall;

  assign fall = pin_q & ~nmi_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q   <= 1'b1;
      pending <= 1'b0;
    end else begin
      pin_q   <= nmi_n;
      pending <= fall | (pending & ~served);
    end
  end
endmodule

// File: rtl/irq_bus_grant.sv
module irq_bus_grant (
  input  logic clk,
  input  logic rst_n,
  input  logic busreq_n,
  input  logic mcyc_end,
  output logic granted,
  output logic grant_take,
  output logic bus_oe
);
  assign grant_take = ~granted & mcyc_end & ~busreq_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      granted <= 1'b0;
      bus_oe  <= 1'b0;
    end else begin
      if (grant_take)             granted <= 1'b1;
      else if (granted && busreq_n) granted <= 1'b0;
      bus_oe <= ~(grant_take | (granted & ~busreq_n));
    end
  end
endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
  import irq_resp_pkg::*;
#(
  parameter int DW        = 8,
  parameter int ACK_WAITS = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take_nmi,
  input  logic            take_int,
  input  logic [1:0]      mode_in,
  input  logic [DW-1:0]   ireg,
  input  logic [DW-1:0]   data_in,
  input  logic            vec_ready,
  output logic            irq_ack,
  output logic            ack_wait,
  output logic            vec_valid,
  output logic [2*DW-1:0] vec_addr,
  output vec_kind_e       vec_kind
);
  localparam int AW         = 2 * DW;
  localparam int ACK_CYCLES = ACK_WAITS + 1;
  localparam int CW         = $clog2(ACK_CYCLES + 1);

  logic [CW-1:0]   cnt;
  int_mode_e       mode_q;
  logic            last;
  logic [AW-1:0]   form_addr;
  vec_kind_e       form_kind;

  assign irq_ack  = (cnt != '0);
  assign ack_wait = (cnt > CW'(1));
  assign last     = (cnt == CW'(1));

  always_comb begin
    unique case (mode_q)
      MODE_OPCODE: begin
        form_addr = AW'(data_in);
        form_kind = VK_OPCODE;
      end
      MODE_TABLE: begin
        form_addr = {ireg, data_in};
        form_kind = VK_TABLE;
      end
      default: begin
        form_addr = AW'(FIXED_TARGET);
        form_kind = VK_FIXED;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      mode_q <= MODE_OPCODE;
    end else if (take_int) begin
      cnt    <= CW'(ACK_CYCLES);
      mode_q <= int_mode_e'(mode_in);
    end else if (cnt != '0) begin
      cnt <= cnt - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_valid <= 1'b0;
      vec_addr  <= '0;
      vec_kind  <= VK_NMI;
    end else if (take_nmi) begin
      vec_valid <= 1'b1;
      vec_addr  <= AW'(NMI_TARGET);
      vec_kind  <= VK_NMI;
    end else if (last) begin
      vec_valid <= 1'b1;
      vec_addr  <= form_addr;
      vec_kind  <= form_kind;
    end else if (vec_valid && vec_ready) begin
      vec_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_resp_ctl.sv
module irq_resp_ctl
  import irq_resp_pkg::*;
#(
  parameter int DW        = 8,
  parameter int ACK_WAITS = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            busreq_n,
  input  logic            nmi_n,
  input  logic            int_n,
  input  logic            mcyc_end,
  input  logic            instr_end,
  input  logic            ie_wr,
  input  logic            ie_wdata,
  input  logic            im_wr,
  input  logic [1:0]      im_wdata,
  input  logic            ireg_wr,
  input  logic [DW-1:0]   ireg_wdata,
  input  logic [DW-1:0]   data_in,
  output logic            busack_n,
  output logic            bus_oe,
  output logic            ie_flag,
  output logic            irq_ack,
  output logic            ack_wait,
  output logic            vec_valid,
  input  logic            vec_ready,
  output logic [2*DW-1:0] vec_addr,
  output logic [1:0]      vec_kind
);
  logic          granted, grant_take, nmi_pend, busy, take_nmi, take_int;
  logic [1:0]    im_q;
  logic [DW-1:0] ireg_q;
  vec_kind_e     kind_w;

  irq_bus_grant u_grant (
    .clk(clk), .rst_n(rst_n), .busreq_n(busreq_n), .mcyc_end(mcyc_end),
    .granted(granted), .grant_take(grant_take), .bus_oe(bus_oe)
  );

  irq_nmi_latch u_nmi (
    .clk(clk), .rst_n(rst_n), .nmi_n(nmi_n), .served(take_nmi), .pending(nmi_pend)
  );

  assign busy     = granted | grant_take | irq_ack | vec_valid;
  assign take_nmi = instr_end & ~busy & nmi_pend;
  assign take_int = instr_end & ~busy & ~nmi_pend & ~int_n & ie_flag;
  assign busack_n = ~granted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_flag <= 1'b0;
      im_q    <= 2'd0;
      ireg_q  <= '0;
    end else begin
      if (take_nmi || take_int) ie_flag <= 1'b0;
      else if (ie_wr)           ie_flag <= ie_wdata;
      if (im_wr)   im_q   <= im_wdata;
      if (ireg_wr) ireg_q <= ireg_wdata;
    end
  end

  irq_ack_seq #(.DW(DW), .ACK_WAITS(ACK_WAITS)) u_ack (
    .clk(clk), .rst_n(rst_n), .take_nmi(take_nmi), .take_int(take_int),
    .mode_in(im_q), .ireg(ireg_q), .data_in(data_in), .vec_ready(vec_ready),
    .irq_ack(irq_ack), .ack_wait(ack_wait), .vec_valid(vec_valid),
    .vec_addr(vec_addr), .vec_kind(kind_w)
  );

  assign vec_kind = kind_w;
endmodule

// File: rtl/irq_resp_ctl_chk.sv
module irq_resp_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busreq_n,
  input logic        mcyc_end,
  input logic        busack_n,
  input logic        bus_oe,
  input logic        ie_flag,
  input logic        irq_ack,
  input logic        vec_valid,
  input logic        vec_ready,
  input logic [15:0] vec_addr,
  input logic [1:0]  vec_kind
);
  // R2
  grant_floats_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busack_n |-> !bus_oe);

  // R2
  grant_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busack_n) |-> ($past(mcyc_end) && !$past(busreq_n)));

  // R3
  no_ack_in_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busack_n |=> !$rose(irq_ack));

  // R6
  ack_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> !vec_valid);

  // R8
  ie_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_ack) |-> !ie_flag);

  // R10
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !vec_ready) |=> (vec_valid && $stable(vec_addr) && $stable(vec_kind)));

  // R4
  nmi_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_kind == 2'd0) |-> vec_addr == 16'h0066);
endmodule

bind irq_resp_ctl irq_resp_ctl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .busreq_n(busreq_n), .mcyc_end(mcyc_end),
  .busack_n(busack_n), .bus_oe(bus_oe), .ie_flag(ie_flag), .irq_ack(irq_ack),
  .vec_valid(vec_valid), .vec_ready(vec_ready), .vec_addr(vec_addr),
  .vec_kind(vec_kind)
);

// File: tb/irq_resp_ctl_tb.sv
module irq_resp_ctl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic busreq_n = 1'b1, nmi_n = 1'b1, int_n = 1'b1;
  logic mcyc_end = 1'b0, instr_end = 1'b0;
  logic ie_wr = 1'b0, ie_wdata = 1'b0, im_wr = 1'b0, ireg_wr = 1'b0;
  logic [1:0] im_wdata = 2'd0;
  logic [7:0] ireg_wdata = 8'd0, data_in = 8'd0;
  logic vec_ready = 1'b0;
  logic busack_n, bus_oe, ie_flag, irq_ack, ack_wait, vec_valid;
  logic [15:0] vec_addr;
  logic [1:0] vec_kind;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  irq_resp_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .busreq_n(busreq_n), .nmi_n(nmi_n), .int_n(int_n),
    .mcyc_end(mcyc_end), .instr_end(instr_end), .ie_wr(ie_wr), .ie_wdata(ie_wdata),
    .im_wr(im_wr), .im_wdata(im_wdata), .ireg_wr(ireg_wr), .ireg_wdata(ireg_wdata),
    .data_in(data_in), .busack_n(busack_n), .bus_oe(bus_oe), .ie_flag(ie_flag),
    .irq_ack(irq_ack), .ack_wait(ack_wait), .vec_valid(vec_valid),
    .vec_ready(vec_ready), .vec_addr(vec_addr), .vec_kind(vec_kind)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic boundary();
    instr_end = 1'b1; mcyc_end = 1'b1;
    step();
    instr_end = 1'b0; mcyc_end = 1'b0;
  endtask

  task automatic consume();
    vec_ready = 1'b1;
    step();
    vec_ready = 1'b0;
    chk("R10", "valid after transfer", int'(vec_valid), 0);
  endtask

  task automatic set_regs(input logic [1:0] m, input logic [7:0] iv, input logic ie);
    im_wr = 1'b1; im_wdata = m; ireg_wr = 1'b1; ireg_wdata = iv; ie_wr = 1'b1; ie_wdata = ie;
    step();
    im_wr = 1'b0; ireg_wr = 1'b0; ie_wr = 1'b0;
  endtask

  task automatic pulse_nmi();
    nmi_n = 1'b0; step(); nmi_n = 1'b1; step();
  endtask

  // Maskable run with expected target computed from R9
  task automatic run_int(input logic [1:0] m, input logic [7:0] iv, input logic [7:0] b);
    logic [15:0] ea;
    int ek;
    if (m == 2'd0)      begin ea = {8'h00, b}; ek = 1; end
    else if (m == 2'd2) begin ea = {iv, b};    ek = 3; end
    else                begin ea = 16'h0038;   ek = 2; end
    set_regs(m, iv, 1'b1);
    chk("R11", "ie written", int'(ie_flag), 1);
    int_n = 1'b0;
    data_in = ~b;
    boundary();
    chk("R6", "ack cycle 1", int'(irq_ack), 1);
    chk("R6", "wait cycle 1", int'(ack_wait), 1);
    chk("R8", "ie cleared", int'(ie_flag), 0);
    data_in = b;
    step();
    chk("R6", "wait cycle 2", int'(ack_wait), 1);
    step();
    chk("R6", "ack cycle 3", int'(irq_ack), 1);
    chk("R6", "no wait in cycle 3", int'(ack_wait), 0);
    step();
    int_n = 1'b1;
    chk("R6", "ack over", int'(irq_ack), 0);
    chk("R9", "vec valid", int'(vec_valid), 1);
    chk("R9", "vec addr", int'(vec_addr), int'(ea));
    chk("R9", "vec kind", int'(vec_kind), ek);
    consume();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(); step();
    // R1 reset state
    chk("R1", "busack_n in reset", int'(busack_n), 1);
    chk("R1", "bus_oe in reset", int'(bus_oe), 0);
    chk("R1", "irq_ack in reset", int'(irq_ack), 0);
    chk("R1", "vec_valid in reset", int'(vec_valid), 0);
    chk("R1", "ie in reset", int'(ie_flag), 0);
    step();
    rst_n = 1'b1;
    step();
    chk("R1", "bus_oe after release", int'(bus_oe), 1);

    // R7 ie clear: INT has no effect
    int_n = 1'b0;
    boundary(); step();
    chk("R7", "no ack with ie clear", int'(irq_ack), 0);
    chk("R7", "no vec with ie clear", int'(vec_valid), 0);
    // R7 no instr_end
    ie_wr = 1'b1; ie_wdata = 1'b1; step(); ie_wr = 1'b0;
    mcyc_end = 1'b1; step(); mcyc_end = 1'b0; step();
    chk("R7", "no ack without instr_end", int'(irq_ack), 0);
    // R1 reset left mode 0 and table register 0
    data_in = 8'h5C;
    boundary(); step(); step(); step();
    int_n = 1'b1;
    chk("R1", "reset mode 0 kind", int'(vec_kind), 1);
    chk("R1", "reset mode 0 addr", int'(vec_addr), 16'h005C);
    consume();

    // R9 sweep over modes, table values and bytes
    for (int m = 0; m < 4; m++)
      for (int i = 0; i < 3; i++)
        for (int k = 0; k < 4; k++) begin
          logic [7:0] iv;
          logic [7:0] bv;
          iv = (i == 0) ? 8'h00 : (i == 1) ? 8'h5A : 8'hFF;
          bv = (k == 0) ? 8'h00 : (k == 1) ? 8'h38 : (k == 2) ? 8'hA5 : 8'hFF;
          run_int(m[1:0], iv, bv);
        end

    // R4 NMI edge held, served with ie clear
    set_regs(2'd1, 8'h00, 1'b0);
    pulse_nmi(); step(); step();
    chk("R4", "no vec before boundary", int'(vec_valid), 0);
    boundary();
    chk("R4", "nmi vec valid", int'(vec_valid), 1);
    chk("R4", "nmi target", int'(vec_addr), 16'h0066);
    chk("R4", "nmi kind", int'(vec_kind), 0);
    chk("R4", "no ack for nmi", int'(irq_ack), 0);
    consume();
    boundary();
    chk("R4", "edge served once", int'(vec_valid), 0);

    // R5 NMI and INT together; R8 NMI clears ie
    set_regs(2'd1, 8'h00, 1'b1);
    int_n = 1'b0;
    pulse_nmi();
    boundary();
    chk("R5", "nmi wins", int'(vec_kind), 0);
    chk("R5", "no ack alongside nmi", int'(irq_ack), 0);
    chk("R8", "ie cleared by nmi", int'(ie_flag), 0);
    consume();
    ie_wr = 1'b1; ie_wdata = 1'b1; step(); ie_wr = 1'b0;
    boundary();
    chk("R5", "int taken later", int'(irq_ack), 1);
    step(); step(); step();
    int_n = 1'b1;
    chk("R5", "int later kind", int'(vec_kind), 2);
    consume();

    // R2 grant only at machine-cycle end
    busreq_n = 1'b0; step(); step();
    chk("R2", "no grant mid cycle", int'(busack_n), 1);
    mcyc_end = 1'b1; step(); mcyc_end = 1'b0;
    chk("R2", "granted", int'(busack_n), 0);
    chk("R2", "buses floated", int'(bus_oe), 0);
    // R3 no interrupt while granted
    pulse_nmi();
    boundary();
    chk("R3", "no vec while granted", int'(vec_valid), 0);
    busreq_n = 1'b1; step();
    chk("R2", "released", int'(busack_n), 1);
    chk("R2", "buses driven", int'(bus_oe), 1);
    boundary();
    chk("R4", "deferred nmi served", int'(vec_addr), 16'h0066);
    chk("R4", "deferred nmi valid", int'(vec_valid), 1);
    consume();

    // R3 grant and INT on the same boundary
    set_regs(2'd1, 8'h00, 1'b1);
    int_n = 1'b0; busreq_n = 1'b0;
    boundary();
    chk("R3", "grant taken", int'(busack_n), 0);
    chk("R3", "int not taken", int'(irq_ack), 0);
    chk("R3", "ie kept", int'(ie_flag), 1);
    busreq_n = 1'b1; int_n = 1'b1; step();

    // R10 stalled stream blocks new acceptance
    set_regs(2'd1, 8'h00, 1'b0);
    pulse_nmi(); boundary();
    pulse_nmi();
    for (int n = 0; n < 3; n++) begin
      boundary();
      chk("R10", "held addr", int'(vec_addr), 16'h0066);
      chk("R10", "held valid", int'(vec_valid), 1);
    end
    consume();
    boundary();
    chk("R10", "second nmi after transfer", int'(vec_valid), 1);
    consume();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule